// File: doc/BRIEF.md
# PCI Target Address Decoder

This block sits on the target side of a PCI slave and handles the address phase of every transaction it sees. It latches the address, command and IDSEL when a transaction starts, and decides whether the device has been addressed. If it has, it claims the cycle with DEVSEL# using medium decode timing and sends the access to one of three places: the local DRAM port, the internal register port, or the block's own configuration header.

A memory cycle is claimed when its upper ten address bits match a base value held in a writable configuration base register. That gives one 4 MB window per device. Inside the window, one address bit chooses between DRAM and registers, and the remaining low bits pass through as the offset. Configuration cycles are claimed only when IDSEL is high. Both memory response and bus mastering are enabled from reset, so no software setup is needed. Each transfer has a single data phase. TRDY# waits for the back end to report ready, and DEVSEL# and TRDY# are released together once the data phase completes.

Top module: `pci_tgt_decode`

## Requirements
- R1: After reset, DEVSEL# and TRDY# are high, the strobe and both port selects are low, and the window base is zero, so a configuration read of header dword 4 returns 0.
- R2: Memory read (command 0110) and memory write (0111) are claimed only when address bits 31:22 equal the window base.
- R3: Within a claimed memory cycle, address bit 21 = 0 raises the DRAM select and bit 21 = 1 raises the register select, and never both.
- R4: The port offset equals address bits 20:0 of the address phase.
- R5: DEVSEL# goes low after the clock edge two cycles after the first edge that samples FRAME# low, and not earlier.
- R6: TRDY# goes low one cycle after DEVSEL# if the port ready input is high, and is held high for every edge at which ready is low.
- R7: At the first edge where IRDY# and TRDY# are both sampled low, DEVSEL# and TRDY# return high together.
- R8: Configuration read (1010) and write (1011) are claimed only when IDSEL is high in the address phase with AD[1:0] = 00. They never assert the port strobe.
- R9: A configuration write to header dword 4 (byte offset 0x10) loads the base from data bits 31:22. A read of dword 4 returns base in 31:22 and zeros in 21:0. Dword 1 reads 0x00000006 (memory response and bus master enabled).
- R10: Every other command encoding is ignored: DEVSEL# stays high.
- R11: When TRDY# goes low on a memory cycle, the strobe is high for exactly one cycle, byte enables = inverted C/BE# from the data phase (bit 0 = lowest-address byte), and the write flag = command bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_n | input | 1 | FRAME#, transaction in progress |
| irdy_n | input | 1 | IRDY#, initiator ready |
| idsel | input | 1 | Configuration select |
| ad | input | 32 | Address in the address phase, write data in the data phase |
| cbe_n | input | 4 | Command in the address phase, byte enables (active low) in the data phase |
| devsel_n | output | 1 | DEVSEL#, cycle claimed |
| trdy_n | output | 1 | TRDY#, target ready |
| cfg_rdata | output | 32 | Configuration header read data for the latched dword |
| tgt_dram_sel | output | 1 | Access routed to local DRAM |
| tgt_reg_sel | output | 1 | Access routed to internal registers |
| tgt_offset | output | 21 | Location offset within the selected half |
| tgt_byte_en | output | 4 | Active-high byte lanes for the data phase |
| tgt_write | output | 1 | 1 = write, 0 = read |
| tgt_strobe | output | 1 | One-cycle access pulse to the selected port |
| tgt_ready | input | 1 | Selected port can complete the data phase |

## Verification
The bench builds the block with its default parameters: a 32-bit address, a 22-bit window (a 4 MB region with a 21-bit offset) and the default ID values. With these sizes the decode edges can be reached with real addresses. These are the last word in the window, the first word past it, a window that has moved after a configuration write, and an address that hit before that write and misses after it. The address widths are fixed, so the bench probes the other dimensions instead: the ready delay, the byte-lane patterns and the write data bits below the base field.

// File: rtl/pci_tgt_pkg.sv
// Shared definitions for the PCI target decoder: bus command codes and the
// sequencer state type. Assumes the standard 4-bit PCI command encoding.
package pci_tgt_pkg;

    localparam logic [3:0] CMD_MEM_RD = 4'b0110;
    localparam logic [3:0] CMD_MEM_WR = 4'b0111;
    localparam logic [3:0] CMD_CFG_RD = 4'b1010;
    localparam logic [3:0] CMD_CFG_WR = 4'b1011;

    localparam int CFG_IDX_W = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECODE,
        ST_WAIT,
        ST_CLAIM,
        ST_DATA,
        ST_BUSY
    } tgt_state_e;

endpackage

// File: rtl/pci_tgt_window.sv
// Combinational hit logic for the latched address phase. Compares the upper
// address field with the window base, recognises configuration cycles and
// picks the half of the window. Assumes inputs are stable after the latch.
module pci_tgt_window
    import pci_tgt_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int WIN_BITS = 22,
    localparam int BASE_W  = ADDR_W - WIN_BITS
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        cmd,
    input  logic              idsel,
    input  logic [BASE_W-1:0] base,
    output logic              hit_mem,
    output logic              hit_cfg,
    output logic              upper_half
);

    logic is_mem_cmd;
    logic is_cfg_cmd;

    // Classify the command and compare the address against the window.
    always_comb begin
        is_mem_cmd = (cmd == CMD_MEM_RD) || (cmd == CMD_MEM_WR);
        is_cfg_cmd = (cmd == CMD_CFG_RD) || (cmd == CMD_CFG_WR);
        hit_mem    = is_mem_cmd && (addr[ADDR_W-1:WIN_BITS] == base);
        hit_cfg    = is_cfg_cmd && idsel && (addr[1:0] == 2'b00);
        upper_half = addr[WIN_BITS-1];
    end

endmodule

// File: rtl/pci_tgt_cfg.sv
// Minimal configuration header: ID dword, command/status dword with memory
// response and bus mastering enabled, and the window base register whose low
// bits read as zero to report the window size. Assumes writes are single dword.
module pci_tgt_cfg
    import pci_tgt_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter int          WIN_BITS  = 22,
    parameter logic [15:0] VENDOR_ID = 16'h1D0F,
    parameter logic [15:0] DEVICE_ID = 16'h4802,
    localparam int         BASE_W    = ADDR_W - WIN_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [CFG_IDX_W-1:0] idx,
    input  logic [ADDR_W-1:0]    wdata,
    output logic [BASE_W-1:0]    base,
    output logic [ADDR_W-1:0]    rdata
);

    localparam logic [CFG_IDX_W-1:0] IDX_ID   = 'd0;
    localparam logic [CFG_IDX_W-1:0] IDX_CMD  = 'd1;
    localparam logic [CFG_IDX_W-1:0] IDX_BASE = 'd4;

    logic [BASE_W-1:0] base_q;

    // Window base register, loaded by a configuration write to its dword.
    always_ff @(posedge clk) begin
        if (!rst_n)
            base_q <= '0;
        else if (we && idx == IDX_BASE)
            base_q <= wdata[ADDR_W-1:WIN_BITS];
    end

    // Read mux over the implemented header dwords.
    always_comb begin
        case (idx)
            IDX_ID:   rdata = ADDR_W'({DEVICE_ID, VENDOR_ID});
            IDX_CMD:  rdata = ADDR_W'(32'h0000_0006);
            IDX_BASE: rdata = {base_q, {WIN_BITS{1'b0}}};
            default:  rdata = '0;
        endcase
    end

    assign base = base_q;

    assert_base_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(base_q));

endmodule

// File: rtl/pci_tgt_seq.sv
// Transaction sequencer: latches the address phase, waits one decode cycle,
// claims with medium DEVSEL# timing, gates TRDY# on port ready and releases
// both after the single data phase. Assumes single-data-phase initiators.
module pci_tgt_seq
    import pci_tgt_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int WIN_BITS = 22,
    localparam int BE_W    = ADDR_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_n,
    input  logic              irdy_n,
    input  logic              idsel,
    input  logic [ADDR_W-1:0] ad,
    input  logic [BE_W-1:0]   cbe_n,
    input  logic              hit_mem,
    input  logic              hit_cfg,
    input  logic              upper_half,
    input  logic              port_ready,
    output logic [ADDR_W-1:0] addr_q,
    output logic [3:0]        cmd_q,
    output logic              idsel_q,
    output logic              devsel_n,
    output logic              trdy_n,
    output logic              dram_sel,
    output logic              reg_sel,
    output logic              write,
    output logic [BE_W-1:0]   byte_en,
    output logic              strobe,
    output logic              cfg_we
);

    tgt_state_e state_q;
    logic       cfg_q;

    // Address-phase latch, taken on the first edge that sees FRAME# low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            cmd_q   <= '0;
            idsel_q <= 1'b0;
        end else if (state_q == ST_IDLE && !frame_n) begin
            addr_q  <= ad;
            cmd_q   <= cbe_n[3:0];
            idsel_q <= idsel;
        end
    end

    // State, claim handshake and port control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            devsel_n <= 1'b1;
            trdy_n   <= 1'b1;
            dram_sel <= 1'b0;
            reg_sel  <= 1'b0;
            cfg_q    <= 1'b0;
            write    <= 1'b0;
            byte_en  <= '0;
            strobe   <= 1'b0;
        end else begin
            strobe <= 1'b0;
            case (state_q)
                ST_IDLE:   if (!frame_n) state_q <= ST_DECODE;
                ST_DECODE: begin
                    dram_sel <= hit_mem && !upper_half;
                    reg_sel  <= hit_mem && upper_half;
                    cfg_q    <= hit_cfg;
                    write    <= cmd_q[0];
                    state_q  <= (hit_mem || hit_cfg) ? ST_WAIT : ST_BUSY;
                end
                ST_WAIT: begin
                    devsel_n <= 1'b0;
                    state_q  <= ST_CLAIM;
                end
                ST_CLAIM: if (port_ready || cfg_q) begin
                    trdy_n  <= 1'b0;
                    byte_en <= ~cbe_n;
                    strobe  <= dram_sel || reg_sel;
                    state_q <= ST_DATA;
                end
                ST_DATA: if (!irdy_n) begin
                    devsel_n <= 1'b1;
                    trdy_n   <= 1'b1;
                    dram_sel <= 1'b0;
                    reg_sel  <= 1'b0;
                    cfg_q    <= 1'b0;
                    state_q  <= frame_n ? ST_IDLE : ST_BUSY;
                end
                ST_BUSY:   if (frame_n && irdy_n) state_q <= ST_IDLE;
                default:   state_q <= ST_IDLE;
            endcase
        end
    end

    // Configuration header write at data-phase completion.
    always_comb cfg_we = (state_q == ST_DATA) && !irdy_n && cfg_q && write;

    assert_medium_devsel_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(devsel_n) |-> $past(state_q) == ST_WAIT);
    assert_trdy_within_claim_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !trdy_n |-> !devsel_n);
    assert_release_together_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(devsel_n) |-> $rose(trdy_n));
    assert_single_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(dram_sel && reg_sel));
    assert_strobe_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);

endmodule

// File: rtl/pci_tgt_decode.sv
// Top of the PCI target decoder. Wires the sequencer, the window compare and
// the configuration header together and exposes the back-end port. Assumes
// the bus is idle when reset is released.
module pci_tgt_decode
    import pci_tgt_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter int          WIN_BITS  = 22,
    parameter logic [15:0] VENDOR_ID = 16'h1D0F,
    parameter logic [15:0] DEVICE_ID = 16'h4802,
    localparam int         BASE_W    = ADDR_W - WIN_BITS,
    localparam int         OFS_W     = WIN_BITS - 1,
    localparam int         BE_W      = ADDR_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_n,
    input  logic              irdy_n,
    input  logic              idsel,
    input  logic [ADDR_W-1:0] ad,
    input  logic [BE_W-1:0]   cbe_n,
    output logic              devsel_n,
    output logic              trdy_n,
    output logic [ADDR_W-1:0] cfg_rdata,
    output logic              tgt_dram_sel,
    output logic              tgt_reg_sel,
    output logic [OFS_W-1:0]  tgt_offset,
    output logic [BE_W-1:0]   tgt_byte_en,
    output logic              tgt_write,
    output logic              tgt_strobe,
    input  logic              tgt_ready
);

    logic [ADDR_W-1:0] addr_q;
    logic [3:0]        cmd_q;
    logic              idsel_q;
    logic              hit_mem;
    logic              hit_cfg;
    logic              upper_half;
    logic [BASE_W-1:0] base;
    logic              cfg_we;

    pci_tgt_seq #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_n    (frame_n),
        .irdy_n     (irdy_n),
        .idsel      (idsel),
        .ad         (ad),
        .cbe_n      (cbe_n),
        .hit_mem    (hit_mem),
        .hit_cfg    (hit_cfg),
        .upper_half (upper_half),
        .port_ready (tgt_ready),
        .addr_q     (addr_q),
        .cmd_q      (cmd_q),
        .idsel_q    (idsel_q),
        .devsel_n   (devsel_n),
        .trdy_n     (trdy_n),
        .dram_sel   (tgt_dram_sel),
        .reg_sel    (tgt_reg_sel),
        .write      (tgt_write),
        .byte_en    (tgt_byte_en),
        .strobe     (tgt_strobe),
        .cfg_we     (cfg_we)
    );

    pci_tgt_window #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS)) u_window (
        .addr       (addr_q),
        .cmd        (cmd_q),
        .idsel      (idsel_q),
        .base       (base),
        .hit_mem    (hit_mem),
        .hit_cfg    (hit_cfg),
        .upper_half (upper_half)
    );

    pci_tgt_cfg #(
        .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS),
        .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID)
    ) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .idx   (addr_q[CFG_IDX_W+1:2]),
        .wdata (ad),
        .base  (base),
        .rdata (cfg_rdata)
    );

    // Offset is the low part of the latched address.
    assign tgt_offset = addr_q[OFS_W-1:0];

    assert_ignored_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(devsel_n) |-> (cmd_q[3:1] == 3'b011) || (cmd_q[3:1] == 3'b101));

endmodule

// File: tb/pci_tgt_decode_tb.sv
module pci_tgt_decode_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_n = 1'b1;
    logic        irdy_n = 1'b1;
    logic        idsel = 1'b0;
    logic [31:0] ad = '0;
    logic [3:0]  cbe_n = 4'hF;
    logic        tgt_ready = 1'b1;
    logic        devsel_n, trdy_n;
    logic [31:0] cfg_rdata;
    logic        tgt_dram_sel, tgt_reg_sel, tgt_write, tgt_strobe;
    logic [20:0] tgt_offset;
    logic [3:0]  tgt_byte_en;

    int checks = 0;
    int fails = 0;

    always #4 clk = ~clk;

    pci_tgt_decode u_dut (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
        .idsel(idsel), .ad(ad), .cbe_n(cbe_n), .devsel_n(devsel_n),
        .trdy_n(trdy_n), .cfg_rdata(cfg_rdata), .tgt_dram_sel(tgt_dram_sel),
        .tgt_reg_sel(tgt_reg_sel), .tgt_offset(tgt_offset),
        .tgt_byte_en(tgt_byte_en), .tgt_write(tgt_write),
        .tgt_strobe(tgt_strobe), .tgt_ready(tgt_ready)
    );

    // Vector: addr[39:8] cmd[7:4] idsel[3] claim[2] dram[1] reg[0]; base is 0.
    localparam logic [39:0] VEC [8] = '{
        {32'h0000_0040, 4'b0110, 1'b0, 1'b1, 1'b1, 1'b0},
        {32'h0020_1234, 4'b0111, 1'b0, 1'b1, 1'b0, 1'b1},
        {32'h003F_FFFC, 4'b0110, 1'b0, 1'b1, 1'b0, 1'b1},
        {32'h001F_FFFC, 4'b0111, 1'b0, 1'b1, 1'b1, 1'b0},
        {32'h0040_0000, 4'b0110, 1'b0, 1'b0, 1'b0, 1'b0},
        {32'h0000_0000, 4'b0010, 1'b0, 1'b0, 1'b0, 1'b0},
        {32'h0000_0010, 4'b1010, 1'b0, 1'b0, 1'b0, 1'b0},
        {32'h0000_0004, 4'b1010, 1'b1, 1'b1, 1'b0, 1'b0}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One single-phase transaction with checks at each cycle of the handshake.
    task automatic txn(input logic [31:0] a, input logic [3:0] cmd, input bit sel,
                       input logic [3:0] ben, input logic [31:0] wd, input int wait_n,
                       input bit claim, input bit dram, input bit regs,
                       input bit chk_rd, input logic [31:0] exp_rd);
        bit is_mem;
        is_mem = (cmd[3:1] == 3'b011);
        @(negedge clk);
        frame_n = 1'b0; ad = a; cbe_n = cmd; idsel = sel;
        tgt_ready = (wait_n == 0);
        @(negedge clk);
        frame_n = 1'b1; irdy_n = 1'b0; cbe_n = ben; ad = wd; idsel = 1'b0;
        chk(devsel_n == 1'b1, "R5 not before decode", 32'(devsel_n), 32'd1);
        @(negedge clk);
        chk(devsel_n == 1'b1, "R5 no fast claim", 32'(devsel_n), 32'd1);
        @(negedge clk);
        if (claim) begin
            chk(devsel_n == 1'b0, "R5 medium claim", 32'(devsel_n), 32'd0);
            if (is_mem) begin
                chk(tgt_dram_sel == dram && tgt_reg_sel == regs, "R3 half select",
                    {tgt_dram_sel, tgt_reg_sel}, {dram, regs});
                chk(tgt_offset == a[20:0], "R4 offset", 32'(tgt_offset), 32'(a[20:0]));
            end
            for (int i = 0; i < wait_n; i++) begin
                @(negedge clk);
                chk(trdy_n == 1'b1, "R6 held while not ready", 32'(trdy_n), 32'd1);
            end
            tgt_ready = 1'b1;
            @(negedge clk);
            chk(trdy_n == 1'b0, "R6 ready", 32'(trdy_n), 32'd0);
            if (is_mem) begin
                chk(tgt_strobe == 1'b1 && tgt_byte_en == ~ben && tgt_write == cmd[0],
                    "R11 strobe/lanes/dir", {tgt_strobe, tgt_byte_en, tgt_write},
                    {1'b1, ~ben, cmd[0]});
            end else begin
                chk(tgt_strobe == 1'b0, "R8 no strobe for config", 32'(tgt_strobe), 32'd0);
            end
            if (chk_rd)
                chk(cfg_rdata == exp_rd, "R9 header read", cfg_rdata, exp_rd);
            @(negedge clk);
            chk(devsel_n && trdy_n, "R7 release together", {devsel_n, trdy_n}, 32'd3);
            chk(tgt_strobe == 1'b0, "R11 strobe one cycle", 32'(tgt_strobe), 32'd0);
        end else begin
            chk(devsel_n == 1'b1, "R10/R8/R2 not claimed", 32'(devsel_n), 32'd1);
            @(negedge clk);
            chk(devsel_n == 1'b1 && !tgt_strobe, "R10/R8/R2 stays unclaimed",
                {devsel_n, tgt_strobe}, 32'd2);
        end
        irdy_n = 1'b1; cbe_n = 4'hF; tgt_ready = 1'b1;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(devsel_n && trdy_n && !tgt_strobe && !tgt_dram_sel && !tgt_reg_sel,
            "R1 reset outputs", {devsel_n, trdy_n, tgt_strobe, tgt_dram_sel, tgt_reg_sel},
            32'h18);
        txn(32'h10, 4'b1010, 1'b1, 4'h0, '0, 0, 1, 0, 0, 1, 32'h0); // R1 base zero

        // Table walk at base 0 (R2, R3, R4, R8, R10)
        for (int k = 0; k < 8; k++) begin
            txn(VEC[k][39:8], VEC[k][7:4], VEC[k][3], 4'b1110, 32'hDEAD_BEEF, 0,
                VEC[k][2], VEC[k][1], VEC[k][0], VEC[k][7:4] == 4'b1010, 32'h6);
        end

        // R6 ready delay with mixed lanes (R11)
        txn(32'h0000_0100, 4'b0111, 1'b0, 4'b0101, '0, 3, 1, 1, 0, 0, '0);
        // R9 move the window; low data bits must not stick
        txn(32'h10, 4'b1011, 1'b1, 4'h0, 32'h0A8F_FFFF, 0, 1, 0, 0, 0, '0);
        txn(32'h10, 4'b1010, 1'b1, 4'h0, '0, 0, 1, 0, 0, 1, 32'h0A80_0000);
        // R2 new window hits, old window misses
        txn(32'h0A80_0040, 4'b0110, 1'b0, 4'b0111, '0, 0, 1, 1, 0, 0, '0);
        txn(32'h0AA0_0008, 4'b0111, 1'b0, 4'b1000, '0, 1, 1, 0, 1, 0, '0);
        txn(32'h0000_0040, 4'b0110, 1'b0, 4'h0, '0, 0, 0, 0, 0, 0, '0);
        // R8 type-1 address bits not claimed; R10 memory-read-multiple ignored
        txn(32'h0000_0005, 4'b1010, 1'b1, 4'h0, '0, 0, 0, 0, 0, 0, '0);
        txn(32'h0A80_0000, 4'b1100, 1'b0, 4'h0, '0, 0, 0, 0, 0, 0, '0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule